// File: doc/BRIEF.md
# Multithreaded Return Address Predictor

This block predicts the target of a subroutine return. Each hardware thread has its own last-in, first-out stack of return addresses. A call pushes the address that follows it, and a return pops the most recent entry. That entry is shown on the prediction outputs in the same cycle as the pop.

One physical array of `ENTRIES` slots holds every stack. The threading mode decides how the array is split. In single-thread and two-thread modes each stack is half the array deep. In four-thread mode each stack is a quarter of the array deep.

The front end can read the current top pointer and entry count of the selected thread and save them with a speculative branch. After a misprediction it writes them back through the restore port. Only the pointer and the count are recovered. Entries written on the wrong path stay overwritten.

Top module: `call_return_stack`

## Requirements
- R1: A pop on an active thread with a non-empty stack raises `pred_valid_o` in the same cycle and shows the most recently pushed address of that thread that has not yet been popped on `pred_addr_o`. Threads never see each other's entries.
- R2: `mode_i` encodes the mode as follows. 0 is one thread (thread 0 only), with 16-deep stacks at the default size. 1 is two threads (0 and 1), with 16-deep stacks. Both 2 and 3 are four threads (0 to 3), with 8-deep stacks.
- R3: A push onto a full stack overwrites its oldest entry. The count stays at the depth, and the newest depth entries pop back in reverse order.
- R4: A pop on an empty stack gives `pred_valid_o` = 0 and leaves the top pointer and the count unchanged.
- R5: A push and a pop on the same thread in one cycle predict the old top entry and then replace it with the pushed address, leaving the count unchanged. If the stack is empty, the pair acts as a plain push with no valid prediction.
- R6: In any cycle where `mode_i` differs from the mode in force, every stack is emptied. All push, pop and restore requests in that cycle are ignored, and no prediction is valid.
- R7: Requests naming a thread id that the mode does not enable are ignored. They give no prediction and do not disturb any other thread's stack.
- R8: A restore sets the named thread's top pointer to `restore_ptr_i` masked to depth-1 and its count to `restore_cnt_i` clamped to the depth. It takes effect at the next clock edge and overrides a push or pop to the same thread in that cycle.
- R9: After synchronous active-low reset the mode is single-thread, every count is 0 and every top pointer is 0.
- R10: `top_ptr_o` and `depth_cnt_o` show the current top pointer and entry count of the thread selected by `tid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Threading mode (0 one, 1 two, 2 or 3 four threads) |
| tid_i | input | 2 | Thread addressed by push, pop and the state outputs |
| push_i | input | 1 | Call: push `push_addr_i` |
| push_addr_i | input | ADDR_W | Return address to store |
| pop_i | input | 1 | Return: pop and predict |
| restore_i | input | 1 | Load a saved pointer and count |
| restore_tid_i | input | 2 | Thread that the restore applies to |
| restore_ptr_i | input | PW | Saved top pointer |
| restore_cnt_i | input | PW+1 | Saved entry count |
| pred_valid_o | output | 1 | Prediction is valid |
| pred_addr_o | output | ADDR_W | Predicted return address |
| top_ptr_o | output | PW | Top pointer of thread `tid_i` |
| depth_cnt_o | output | PW+1 | Entry count of thread `tid_i` |

## Verification
The bench first pushes a short run of addresses and drains it, which separates true last-in ordering from queue or fixed-slot behaviour. It then pushes more addresses than the stack holds, in both the deep and the shallow modes. This shows whether the oldest entries are the ones lost and whether the depth follows the mode. Interleaved traffic on two or three threads, including requests to a thread the mode disables, reveals any region overlap between threads. Combined push-and-pop, a mode switch with a pop in the same cycle, and restores with a competing push or out-of-range values each test one precedence rule.

// File: rtl/crs_pkg.sv
// Shared types and helpers for the call/return stack.
// Assumes at most four hardware threads.
package crs_pkg;

    typedef enum logic [1:0] {
        MODE_SOLO  = 2'd0,
        MODE_PAIR  = 2'd1,
        MODE_QUAD  = 2'd2,
        MODE_QUAD2 = 2'd3
    } crs_mode_e;

    // Number of threads a mode enables.
    function automatic logic [2:0] threads_in_mode(input logic [1:0] m);
        case (m)
            MODE_SOLO: threads_in_mode = 3'd1;
            MODE_PAIR: threads_in_mode = 3'd2;
            default:   threads_in_mode = 3'd4;
        endcase
    endfunction

    // True when a mode uses the shallow (quarter-array) stacks.
    function automatic logic is_shallow(input logic [1:0] m);
        is_shallow = (m == MODE_QUAD) || (m == MODE_QUAD2);
    endfunction

endpackage

// File: rtl/crs_geometry.sv
// Maps the threading mode to the per-thread stack depth, the pointer
// mask, the thread enable vector and each thread's base slot.
// Assumes ENTRIES is a power of two and THREADS is four.
module crs_geometry #(
    parameter int ENTRIES = 32,
    parameter int THREADS = 4,
    localparam int DEEP   = ENTRIES / 2,
    localparam int SHALLOW = ENTRIES / 4,
    localparam int PW     = $clog2(DEEP),
    localparam int CW     = PW + 1,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic [1:0]                    mode,
    output logic [CW-1:0]                 depth,
    output logic [PW-1:0]                 ptr_mask,
    output logic [THREADS-1:0]            thread_on,
    output logic [THREADS-1:0][IW-1:0]    base
);
    import crs_pkg::*;

    logic [2:0] nthr;

    // Depth and mask follow the mode.
    always_comb begin
        nthr     = threads_in_mode(mode);
        depth    = is_shallow(mode) ? CW'(SHALLOW) : CW'(DEEP);
        ptr_mask = PW'(depth - CW'(1));
    end

    // Each thread gets a region of 'depth' slots starting at t*depth.
    for (genvar t = 0; t < THREADS; t++) begin : g_region
        assign thread_on[t] = (t < int'(nthr));
        assign base[t]      = IW'(t * int'(depth));
    end

endmodule

// File: rtl/crs_thread_ctl.sv
// Top pointer and entry count of one thread's stack.
// Assumes that push/pop/restore are already qualified by the caller
// (thread enabled, no mode change, restore priority applied).
module crs_thread_ctl #(
    parameter int PW = 4,
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] depth,
    input  logic [PW-1:0] ptr_mask,
    input  logic          push,
    input  logic          pop,
    input  logic          restore,
    input  logic [PW-1:0] rptr,
    input  logic [CW-1:0] rcnt,
    output logic [PW-1:0] ptr,
    output logic [CW-1:0] cnt,
    output logic [PW-1:0] wr_ptr
);
    logic          empty;
    logic          swap;
    logic [PW-1:0] ptr_up;
    logic [PW-1:0] ptr_dn;

    // Neighbour slots and the push-with-pop replace case.
    always_comb begin
        empty  = (cnt == '0);
        swap   = push && pop && !empty;
        ptr_up = (ptr + PW'(1)) & ptr_mask;
        ptr_dn = (ptr - PW'(1)) & ptr_mask;
        wr_ptr = swap ? ptr : ptr_up;
    end

    // Pointer and count update, priority clear > restore > push > pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr <= '0;
            cnt <= '0;
        end else if (restore) begin
            ptr <= rptr & ptr_mask;
            cnt <= (rcnt > depth) ? depth : rcnt;
        end else if (push && !swap) begin
            ptr <= ptr_up;
            cnt <= (cnt == depth) ? depth : cnt + CW'(1);
        end else if (pop && !push && !empty) begin
            ptr <= ptr_dn;
            cnt <= cnt - CW'(1);
        end
    end

endmodule

// File: rtl/crs_entry_array.sv
// Flat storage for all return addresses: one write port, one
// asynchronous read port. Assumes one write per cycle at most.
module crs_entry_array #(
    parameter int ENTRIES = 32,
    parameter int ADDR_W  = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [IW-1:0]     ridx,
    output logic [ADDR_W-1:0] rdata
);
    logic [ADDR_W-1:0] slot [ENTRIES];

    // Store one return address.
    always_ff @(posedge clk) begin
        if (we) slot[widx] <= wdata;
    end

    // Read the selected slot.
    assign rdata = slot[ridx];

endmodule

// File: rtl/call_return_stack.sv
// Per-thread return address stack with mode-dependent partitioning.
// Assumes four thread ids; inactive ids are ignored. Prediction is
// combinational from the selected thread's top entry.
module call_return_stack #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 32,
    parameter int THREADS = 4,
    localparam int DEEP   = ENTRIES / 2,
    localparam int PW     = $clog2(DEEP),
    localparam int CW     = PW + 1,
    localparam int IW     = $clog2(ENTRIES),
    localparam int TW     = $clog2(THREADS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [TW-1:0]     tid_i,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    input  logic              restore_i,
    input  logic [TW-1:0]     restore_tid_i,
    input  logic [PW-1:0]     restore_ptr_i,
    input  logic [CW-1:0]     restore_cnt_i,
    output logic              pred_valid_o,
    output logic [ADDR_W-1:0] pred_addr_o,
    output logic [PW-1:0]     top_ptr_o,
    output logic [CW-1:0]     depth_cnt_o
);
    import crs_pkg::*;

    logic [1:0]                 mode_q;
    logic                       mode_chg;
    logic [CW-1:0]              depth;
    logic [PW-1:0]              ptr_mask;
    logic [THREADS-1:0]         thread_on;
    logic [THREADS-1:0][IW-1:0] base;
    logic [THREADS-1:0][PW-1:0] ptr_v;
    logic [THREADS-1:0][CW-1:0] cnt_v;
    logic [THREADS-1:0][PW-1:0] wptr_v;
    logic                       sel_on;
    logic                       sel_restored;
    logic                       wr_en;
    logic [IW-1:0]              wr_idx;
    logic [IW-1:0]              rd_idx;

    // Mode in force; a difference from mode_i marks a switch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SOLO;
        else        mode_q <= mode_i;
    end

    assign mode_chg = (mode_i != mode_q);

    crs_geometry #(.ENTRIES(ENTRIES), .THREADS(THREADS)) u_geom (
        .mode      (mode_q),
        .depth     (depth),
        .ptr_mask  (ptr_mask),
        .thread_on (thread_on),
        .base      (base)
    );

    // One pointer/count controller per thread.
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic hit;
        logic rhit;

        assign hit  = (tid_i == TW'(t)) && thread_on[t] && !mode_chg;
        assign rhit = restore_i && (restore_tid_i == TW'(t)) && thread_on[t] && !mode_chg;

        crs_thread_ctl #(.PW(PW)) u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (mode_chg),
            .depth    (depth),
            .ptr_mask (ptr_mask),
            .push     (hit && push_i && !rhit),
            .pop      (hit && pop_i && !rhit),
            .restore  (rhit),
            .rptr     (restore_ptr_i),
            .rcnt     (restore_cnt_i),
            .ptr      (ptr_v[t]),
            .cnt      (cnt_v[t]),
            .wr_ptr   (wptr_v[t])
        );
    end

    // Qualify the selected thread and form array indices.
    always_comb begin
        sel_on       = thread_on[tid_i] && !mode_chg;
        sel_restored = restore_i && (restore_tid_i == tid_i);
        wr_en        = push_i && sel_on && !sel_restored;
        wr_idx       = base[tid_i] + IW'(wptr_v[tid_i]);
        rd_idx       = base[tid_i] + IW'(ptr_v[tid_i]);
        top_ptr_o    = ptr_v[tid_i];
        depth_cnt_o  = cnt_v[tid_i];
        pred_valid_o = pop_i && sel_on && !sel_restored && (cnt_v[tid_i] != '0);
    end

    crs_entry_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .widx  (wr_idx),
        .wdata (push_addr_i),
        .ridx  (rd_idx),
        .rdata (pred_addr_o)
    );

endmodule

// File: rtl/crs_checker.sv
// Temporal checks on the call/return stack, bound to the top module.
// Assumes the default four-thread geometry.
module crs_checker #(
    parameter int ENTRIES = 32,
    localparam int PW = $clog2(ENTRIES / 2),
    localparam int CW = PW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic [1:0]    mode_q,
    input logic [1:0]    tid_i,
    input logic          push_i,
    input logic          pop_i,
    input logic          restore_i,
    input logic          pred_valid_o,
    input logic [PW-1:0] top_ptr_o,
    input logic [CW-1:0] depth_cnt_o
);
    logic [CW-1:0] lim;
    logic [2:0]    nthr;

    // Depth and thread count the mode in force allows.
    always_comb begin
        lim  = (mode_q >= 2'd2) ? CW'(ENTRIES / 4) : CW'(ENTRIES / 2);
        nthr = (mode_q == 2'd0) ? 3'd1 : (mode_q == 2'd1) ? 3'd2 : 3'd4;
    end

    p_pred_needs_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o |-> pop_i);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        depth_cnt_o <= lim);

    p_full_push_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !restore_i && mode_i == mode_q && depth_cnt_o == lim)
        |=> (tid_i != $past(tid_i)) || (depth_cnt_o == $past(depth_cnt_o)));

    p_empty_pop_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && depth_cnt_o == '0) |-> !pred_valid_o);

    p_empty_pop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !restore_i && mode_i == mode_q && depth_cnt_o == '0)
        |=> (tid_i != $past(tid_i)) || (depth_cnt_o == '0 && top_ptr_o == $past(top_ptr_o)));

    p_mode_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_q) |=> (depth_cnt_o == '0));

    p_switch_no_pred_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_q) |-> !pred_valid_o);

    p_inactive_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, tid_i} >= nthr) |-> !pred_valid_o);

endmodule

bind call_return_stack crs_checker #(.ENTRIES(ENTRIES)) u_crs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .mode_q       (mode_q),
    .tid_i        (tid_i),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .restore_i    (restore_i),
    .pred_valid_o (pred_valid_o),
    .top_ptr_o    (top_ptr_o),
    .depth_cnt_o  (depth_cnt_o)
);

// File: tb/call_return_stack_test.sv
`timescale 1ns/1ps
module call_return_stack_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic [1:0]    tid_i = 2'd0;
    logic          push_i = 1'b0;
    logic [AW-1:0] push_addr_i = '0;
    logic          pop_i = 1'b0;
    logic          restore_i = 1'b0;
    logic [1:0]    restore_tid_i = 2'd0;
    logic [3:0]    restore_ptr_i = '0;
    logic [4:0]    restore_cnt_i = '0;
    logic          pred_valid_o;
    logic [AW-1:0] pred_addr_o;
    logic [3:0]    top_ptr_o;
    logic [4:0]    depth_cnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    call_return_stack uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tid_i(tid_i),
        .push_i(push_i), .push_addr_i(push_addr_i), .pop_i(pop_i),
        .restore_i(restore_i), .restore_tid_i(restore_tid_i),
        .restore_ptr_i(restore_ptr_i), .restore_cnt_i(restore_cnt_i),
        .pred_valid_o(pred_valid_o), .pred_addr_o(pred_addr_o),
        .top_ptr_o(top_ptr_o), .depth_cnt_o(depth_cnt_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        push_i = 0; pop_i = 0; restore_i = 0;
    endtask

    task automatic do_push(input logic [1:0] t, input logic [AW-1:0] a);
        @(negedge clk); tid_i = t; push_i = 1; push_addr_i = a;
        @(posedge clk); #1 idle();
    endtask

    // Pop and check the same-cycle prediction.
    task automatic pop_chk(input logic [1:0] t, input bit ev, input logic [AW-1:0] ea, input string req);
        @(negedge clk); tid_i = t; pop_i = 1; #1;
        check(pred_valid_o == ev, req, 32'(pred_valid_o), 32'(ev));
        if (ev) check(pred_addr_o == ea, req, pred_addr_o, ea);
        @(posedge clk); #1 idle();
    endtask

    task automatic pushpop_chk(input logic [1:0] t, input logic [AW-1:0] a, input bit ev, input logic [AW-1:0] ea, input string req);
        @(negedge clk); tid_i = t; push_i = 1; pop_i = 1; push_addr_i = a; #1;
        check(pred_valid_o == ev, req, 32'(pred_valid_o), 32'(ev));
        if (ev) check(pred_addr_o == ea, req, pred_addr_o, ea);
        @(posedge clk); #1 idle();
    endtask

    task automatic cnt_chk(input logic [1:0] t, input logic [4:0] ec, input string req);
        @(negedge clk); tid_i = t; #1;
        check(depth_cnt_o == ec, req, 32'(depth_cnt_o), 32'(ec));
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode_i = m;
        @(posedge clk); #1;
    endtask

    task automatic do_restore(input logic [1:0] t, input logic [3:0] p, input logic [4:0] c, input bit with_push, input logic [AW-1:0] a);
        @(negedge clk);
        restore_i = 1; restore_tid_i = t; restore_ptr_i = p; restore_cnt_i = c;
        tid_i = t; push_i = with_push; push_addr_i = a;
        @(posedge clk); #1 idle();
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cnt_chk(0, 0, "R9 count after reset");
        check(top_ptr_o == 0, "R9 pointer after reset", 32'(top_ptr_o), 0);
        pop_chk(0, 0, 0, "R4 pop on empty after reset");
        cnt_chk(0, 0, "R4 count kept on empty pop");
        check(top_ptr_o == 0, "R4 pointer kept on empty pop", 32'(top_ptr_o), 0);
    endtask

    task automatic t_lifo();
        do_push(0, 32'h100); do_push(0, 32'h104); do_push(0, 32'h108);
        cnt_chk(0, 3, "R10 count after three pushes");
        pop_chk(0, 1, 32'h108, "R1 lifo first");
        pop_chk(0, 1, 32'h104, "R1 lifo second");
        pop_chk(0, 1, 32'h100, "R1 lifo third");
        pop_chk(0, 0, 0, "R4 drained stack");
    endtask

    task automatic t_overflow_deep();
        for (int i = 0; i < 20; i++) do_push(0, 32'h1000 + 32'(4*i));
        cnt_chk(0, 16, "R3 count saturates at 16 in mode 0 (R2)");
        for (int i = 19; i >= 4; i--) pop_chk(0, 1, 32'h1000 + 32'(4*i), "R3 newest 16 survive wrap");
        pop_chk(0, 0, 0, "R3 oldest four lost");
    endtask

    task automatic t_pushpop();
        do_push(0, 32'hA0); do_push(0, 32'hB0);
        pushpop_chk(0, 32'hC0, 1, 32'hB0, "R5 push+pop predicts old top");
        cnt_chk(0, 2, "R5 count unchanged by push+pop");
        pop_chk(0, 1, 32'hC0, "R5 top replaced");
        pop_chk(0, 1, 32'hA0, "R5 entry below untouched");
        pushpop_chk(0, 32'hD0, 0, 0, "R5 push+pop on empty no prediction");
        cnt_chk(0, 1, "R5 push+pop on empty acts as push");
        pop_chk(0, 1, 32'hD0, "R5 pushed value from empty pair");
    endtask

    task automatic t_pair();
        do_push(0, 32'h55);
        set_mode(1);
        cnt_chk(0, 0, "R6 mode change empties thread 0");
        do_push(0, 32'h200); do_push(1, 32'h300);
        pop_chk(1, 1, 32'h300, "R1 thread 1 own entry");
        pop_chk(0, 1, 32'h200, "R1 thread 0 own entry");
        do_push(0, 32'h210);
        for (int i = 0; i < 17; i++) do_push(1, 32'h600 + 32'(4*i));
        cnt_chk(1, 16, "R2 thread 1 depth 16 in mode 1");
        pop_chk(0, 1, 32'h210, "R1 thread 0 unharmed by thread 1 wrap");
    endtask

    task automatic t_inactive();
        do_push(0, 32'h220);
        do_push(2, 32'hBAD);
        pop_chk(2, 0, 0, "R7 inactive thread gives no prediction");
        cnt_chk(2, 0, "R7 inactive thread count stays 0");
        pop_chk(0, 1, 32'h220, "R7 inactive push leaves thread 0 intact");
    endtask

    task automatic t_switch_cycle();
        do_push(0, 32'h230);
        @(negedge clk); mode_i = 2; tid_i = 0; pop_i = 1; #1;
        check(pred_valid_o == 0, "R6 no prediction in switch cycle", 32'(pred_valid_o), 0);
        @(posedge clk); #1 idle();
        cnt_chk(0, 0, "R6 switch empties stack");
    endtask

    task automatic t_quad();
        set_mode(2);
        do_push(2, 32'h2F0);
        for (int i = 0; i < 10; i++) do_push(3, 32'h3000 + 32'(4*i));
        cnt_chk(3, 8, "R2 depth 8 in mode 2");
        for (int i = 9; i >= 2; i--) pop_chk(3, 1, 32'h3000 + 32'(4*i), "R3 shallow wrap order");
        pop_chk(3, 0, 0, "R3 shallow oldest lost");
        pop_chk(2, 1, 32'h2F0, "R1 thread 2 independent of thread 3");
    endtask

    task automatic t_restore();
        logic [3:0] sp;
        logic [4:0] sc;
        do_push(1, 32'h400); do_push(1, 32'h404);
        cnt_chk(1, 2, "R10 count before save");
        sp = top_ptr_o; sc = depth_cnt_o;
        do_push(1, 32'h408); do_push(1, 32'h40C);
        do_restore(1, sp, sc, 1, 32'h500);
        cnt_chk(1, 2, "R8 restore wins over push");
        check(top_ptr_o == sp, "R8 pointer restored", 32'(top_ptr_o), 32'(sp));
        pop_chk(1, 1, 32'h404, "R8 pop after restore");
        pop_chk(1, 1, 32'h400, "R8 second pop after restore");
        do_restore(1, 4'hF, 5'd20, 0, 0);
        cnt_chk(1, 8, "R8 count clamped to depth");
        check(top_ptr_o == 4'h7, "R8 pointer masked", 32'(top_ptr_o), 7);
    endtask

    task automatic t_mode3();
        set_mode(3);
        cnt_chk(1, 0, "R6 switch 2->3 empties");
        for (int i = 0; i < 9; i++) do_push(3, 32'h7000 + 32'(i));
        cnt_chk(3, 8, "R2 mode 3 is four-thread depth 8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lifo();
        t_overflow_deep();
        t_pushpop();
        t_pair();
        t_inactive();
        t_switch_cycle();
        t_quad();
        t_restore();
        t_mode3();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule